// File: doc/BRIEF.md
# Per-CPU Interrupt Controller Countdown Timer

This block is the countdown timer of a per-CPU interrupt controller. Software programs it through four word registers on a simple register bus: a timer vector entry, an initial count, a read-only current count and a divide setting. After an initial count is written, the counter steps down once every 2^shift clocks. When it expires and the vector entry is unmasked, the block raises a one-cycle, edge-type interrupt request that carries the 8-bit vector held in the entry.

The vector entry chooses between one-shot and periodic operation. In one-shot mode the counter stops at zero. In periodic mode it reloads from the initial count each time it expires. Prioritisation, request and in-service bookkeeping, and delivery to other processors are handled elsewhere. This block only produces the timer's request.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset the current count and the initial count read 0, the divide setting reads 0, the vector entry reads 0x00010000 (masked, one-shot, vector 0), and irq_req is low.
- R2: A write to the divide register (offset 3) keeps only bits 3, 1 and 0, so a read returns the written value ANDed with 0xB.
- R3: The shift is the 3-bit value {bit 3, bit 1, bit 0} of the divide register plus one, modulo 8 (so 0xB gives divide-by-1 and 0x0 gives divide-by-2). After a write of N to the initial count, the first expiry pulse appears exactly N*2^shift clock edges after the write edge.
- R4: A write to the initial count (offset 1) loads the counter and restarts the prescaler. With divide-by-1, a read in the cycle after the write returns N and the next read returns N-1.
- R5: The current-count register (offset 2) is read-only: writes to it change nothing.
- R6: On expiry with vector-entry bit 16 clear, irq_req is high for exactly one cycle with irq_vec equal to entry bits 7:0. With bit 16 set, no request is raised.
- R7: In one-shot mode (entry bit 17 clear), the counter stops at zero after expiry, reads back 0 and raises no further requests.
- R8: In periodic mode (entry bit 17 set), the counter reloads from the initial count on expiry, and requests repeat every N*2^shift clocks.
- R9: Writing an initial count of 0 stops the timer. The current count reads 0 and no request is raised.
- R10: If an initial-count write lands on the same edge as an expiry, the write wins: no request is raised for that expiry, and the next one comes N_new*2^shift edges later.
- R11: The vector entry (offset 0) stores bits 17, 16 and 7:0 and reads back 0 elsewhere. Changes to the mask and mode bits apply at the next expiry. Writing the entry with bit 17 set while the timer is stopped and the initial count is nonzero restarts the countdown from the initial count.
- R12: bus_rdata is updated one cycle after a read is sampled. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_req | output | 1 | One-cycle edge-type interrupt request |
| irq_vec | output | 8 | Vector that accompanies irq_req |

## Verification
Two events can fall on the same clock edge: an initial-count write and the tick that would expire the current countdown. The bench provokes this by starting a divide-by-1 periodic countdown of 4 and then timing a second initial-count write so that it is sampled on exactly the fourth edge. The pass criteria are that no request appears after that edge and that the next request arrives exactly five edges later. A second overlap, a vector-entry write while the timer is running, is judged by checking that masking suppresses pulses that would otherwise repeat, and that unmasking brings them back within one period.

// File: rtl/loc_irq_timer_pkg.sv
package loc_irq_timer_pkg;
  localparam int VEC_W      = 8;
  localparam int SHIFT_W    = 3;
  localparam int MASK_BIT   = 16;
  localparam int MODE_BIT   = 17;
  localparam int OFS_ENTRY  = 0;
  localparam int OFS_INIT   = 1;
  localparam int OFS_CUR    = 2;
  localparam int OFS_DIV    = 3;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;
endpackage

// File: rtl/loc_irq_timer_regs.sv
module loc_irq_timer_regs
  import loc_irq_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       cur_count,
  output logic [DATA_W-1:0]       bus_rdata,
  output entry_t                  entry,
  output logic [DATA_W-1:0]       init_val,
  output logic [SHIFT_W-1:0]      shift,
  output logic                    init_wr,
  output logic                    entry_wr
);
  logic [SHIFT_W-1:0] div_field;
  logic [DATA_W-1:0]  rd_mux;
  logic               div_wr;

  assign init_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_INIT));
  assign entry_wr = bus_wr && (bus_addr == ADDR_W'(OFS_ENTRY));
  assign div_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));

  // exponent = {bit3, bit1, bit0}; shift = exponent + 1 wrapping in 3 bits
  assign shift = div_field + SHIFT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      entry     <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
      init_val  <= '0;
      div_field <= '0;
    end else begin
      if (entry_wr) begin
        entry.periodic <= bus_wdata[MODE_BIT];
        entry.mask     <= bus_wdata[MASK_BIT];
        entry.vec      <= bus_wdata[VEC_W-1:0];
      end
      if (init_wr) init_val <= bus_wdata;
      if (div_wr)  div_field <= {bus_wdata[3], bus_wdata[1:0]};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_ENTRY)) begin
      rd_mux[MODE_BIT]    = entry.periodic;
      rd_mux[MASK_BIT]    = entry.mask;
      rd_mux[VEC_W-1:0]   = entry.vec;
    end else if (bus_addr == ADDR_W'(OFS_INIT)) begin
      rd_mux = init_val;
    end else if (bus_addr == ADDR_W'(OFS_CUR)) begin
      rd_mux = cur_count;
    end else if (bus_addr == ADDR_W'(OFS_DIV)) begin
      rd_mux[3]   = div_field[2];
      rd_mux[1:0] = div_field[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2: bit 2 of the stored divide setting can never read back as one
  a_r2_div_bit2_clear: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd) && ($past(bus_addr) == ADDR_W'(OFS_DIV)) |-> bus_rdata[2] == 1'b0);
endmodule

// File: rtl/loc_irq_timer_presc.sv
module loc_irq_timer_presc #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] sel_mask;

  assign sel_mask = (PRE_W'(1) << shift) - PRE_W'(1);
  assign tick     = (presc & sel_mask) == sel_mask;

  always_ff @(posedge clk) begin
    if (rst || clear) presc <= '0;
    else              presc <= presc + PRE_W'(1);
  end

  // R4: a load restarts the prescaler phase
  a_r4_presc_restart: assert property (@(posedge clk) disable iff (rst)
    clear |=> presc == '0);
endmodule

// File: rtl/loc_irq_timer_count.sv
module loc_irq_timer_count
  import loc_irq_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               init_wr,
  input  logic               entry_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  init_val,
  input  entry_t             entry,
  output logic [DATA_W-1:0]  count,
  output logic               load,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  logic running;
  logic rearm;
  logic expire;

  assign rearm  = entry_wr && wdata[MODE_BIT] && !running && (init_val != '0);
  assign load   = init_wr || rearm;
  assign expire = running && tick && (count == DATA_W'(1)) && !init_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= expire && !entry.mask;
      if (expire && !entry.mask) irq_vec <= entry.vec;
      if (init_wr) begin
        count   <= wdata;
        running <= (wdata != '0);
      end else if (rearm) begin
        count   <= init_val;
        running <= 1'b1;
      end else if (running && tick) begin
        if (count == DATA_W'(1)) begin
          if (entry.periodic) begin
            count <= init_val;
          end else begin
            count   <= '0;
            running <= 1'b0;
          end
        end else begin
          count <= count - DATA_W'(1);
        end
      end
    end
  end

  // R9: a stopped timer always holds zero, a running one never does
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !running |-> count == '0);
  a_r9_run_nonzero: assert property (@(posedge clk) disable iff (rst)
    running |-> count != '0);
  // R6: no request follows a masked entry
  a_r6_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !$past(entry.mask));
  // R7: one-shot expiry parks at zero
  a_r7_oneshot_park: assert property (@(posedge clk) disable iff (rst)
    expire && !entry.periodic |=> !running && count == '0);
  // R8: periodic expiry reloads
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    expire && entry.periodic |=> running && count == $past(init_val));
  // R10: a count write on the expiry edge suppresses the request
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> !irq_req);
endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import loc_irq_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  entry_t             entry;
  logic [DATA_W-1:0]  init_val;
  logic [DATA_W-1:0]  count;
  logic [SHIFT_W-1:0] shift;
  logic               init_wr;
  logic               entry_wr;
  logic               load;
  logic               tick;

  loc_irq_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_count(count),
    .bus_rdata(bus_rdata), .entry(entry), .init_val(init_val),
    .shift(shift), .init_wr(init_wr), .entry_wr(entry_wr)
  );

  loc_irq_timer_presc #(.SHIFT_W(SHIFT_W)) u_presc (
    .clk(clk), .rst(rst), .clear(load), .shift(shift), .tick(tick)
  );

  loc_irq_timer_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .init_wr(init_wr),
    .entry_wr(entry_wr), .wdata(bus_wdata), .init_val(init_val),
    .entry(entry), .count(count), .load(load),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );
endmodule

// File: tb/loc_irq_timer_tb.sv
`timescale 1ns/1ps
module loc_irq_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  loc_irq_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // edges until irq_req is seen high, -1 when not within lim
  task automatic wait_irq(input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_req) begin k = i; break; end
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_req) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_req", irq_req, 0);
    rd(0, d); check("R1 entry", d, 32'h0001_0000);
    rd(1, d); check("R1 init", d, 0);
    rd(2, d); check("R1 cur", d, 0);
    rd(3, d); check("R1 div", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3, 32'hFFFF_FFFF); rd(3, d); check("R2 div mask", d, 32'hB);
    wr(0, 32'hFFFF_FFFF); rd(0, d); check("R11 entry bits", d, 32'h0003_00FF);
    rd(7, d); check("R12 unmapped", d, 0);
    wr(0, 32'h0001_0000);
  endtask

  task automatic t_oneshot();
    logic [31:0] d; int k;
    wr(3, 32'hB); wr(0, 32'h21); wr(1, 5);
    wait_irq(50, k); check("R3 divide-by-1 delay", k, 5);
    check("R6 vector", irq_vec, 8'h21);
    idle(1); check("R6 one cycle", irq_req, 0);
    rd(2, d); check("R7 parked zero", d, 0);
    quiet(20, "R7 no repeat");
    wr(2, 32'h55); rd(2, d); check("R5 read-only", d, 0);
    quiet(10, "R5 no start");
  endtask

  task automatic t_divide();
    int k;
    wr(3, 32'h0); wr(1, 3); wait_irq(100, k); check("R3 cfg0 shift1", k, 6);
    wr(3, 32'h8); wr(1, 2); wait_irq(200, k); check("R3 cfg8 shift5", k, 64);
    wr(3, 32'h3); wr(1, 1); wait_irq(100, k); check("R3 cfg3 shift4", k, 16);
  endtask

  task automatic t_restart_zero();
    logic [31:0] d;
    wr(3, 32'hB); wr(1, 100);
    rd(2, d); check("R4 loaded", d, 100);
    rd(2, d); check("R4 first step", d, 99);
    wr(1, 0); rd(2, d); check("R9 zero count", d, 0);
    quiet(200, "R9 silent");
  endtask

  task automatic t_periodic();
    int k;
    wr(0, 32'h0002_0042); wr(1, 3);
    wait_irq(20, k); check("R8 first period", k, 3);
    check("R8 vector", irq_vec, 8'h42);
    wait_irq(20, k); check("R8 second period", k, 3);
    wr(0, 32'h0003_0042); quiet(20, "R6 masked periodic");
    wr(0, 32'h0002_0042); wait_irq(3, k);
    check("R11 unmask next expiry", (k >= 1) ? 1 : 0, 1);
    wr(1, 0);
  endtask

  task automatic t_collide();
    int k;
    wr(0, 32'h0002_0042); wr(3, 32'hB); wr(1, 4);
    idle(3);
    wr(1, 5); check("R10 no pulse on overlap", irq_req, 0);
    wait_irq(20, k); check("R10 restart delay", k, 5);
    wr(1, 0);
  endtask

  task automatic t_rearm();
    int k;
    wr(0, 32'h21); wr(1, 3);
    wait_irq(20, k); check("R7 one-shot delay", k, 3);
    wr(0, 32'h0002_0021);
    wait_irq(20, k); check("R11 rearm first", k, 3);
    wait_irq(20, k); check("R11 rearm periodic", k, 3);
    wr(1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regs();
    t_oneshot();
    t_divide();
    t_restart_zero();
    t_periodic();
    t_collide();
    t_rearm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule